// File: doc/BRIEF.md
# Coprocessor Operand Memory Writer

This block carries out one response command from a coprocessor. The command asks for an operand of a given byte count to be copied from the coprocessor's operand register into main memory. The destination is an effective address that an earlier command of the same instruction has already computed and latched. The block does not check that address at all. The block accepts the command together with the byte count, the latched address, the current privilege bit and the two common control bits (CA and PC). It then pulls 32-bit operand words through a valid/ready read handshake and issues one sized write per word on a simple request/acknowledge memory bus. When the last write is acknowledged it pulses `done`.

Counts from 0 to 255 bytes are supported. The operand is cut into whole 4-byte parts, followed by at most one tail of exactly 1, 2 or 3 bytes. Parts go to ascending addresses. A private counter steps the address, so the latched address and every processor register are left unchanged. The function code of every write is fixed by the privilege bit as it was sampled when the command was accepted.

Back-pressure rules:
- A command is taken only in a cycle with `cmd_valid` and `cmd_ready` both high.
- An operand word is taken only in a cycle with `opnd_valid` and `opnd_ready` both high. The block does not raise `opnd_ready` while a memory write is waiting for its acknowledge.
- A write is held on the bus until `mem_ack`.

Top module: `opnd_mem_writer`

## Requirements
- R1: For a count L, the block performs floor(L/4) writes of 4 bytes, followed by one write of L mod 4 bytes when that value is nonzero. It makes exactly one operand read per write.
- R2: The first write goes to the latched address sampled at acceptance. Each later write goes to the previous write's address plus the previous write's size (ascending, modulo 2^32).
- R3: `mem_size` gives the byte count of the write as a binary value from 1 to 4, and is valid whenever `mem_req` is high.
- R4: `mem_fc` is 3'b101 (supervisor data) when `cmd_super` was 1 at acceptance, and 3'b001 (user data) when it was 0. Later changes of `cmd_super` during the transfer have no effect.
- R5: A count of 0 raises `done` in the cycle after acceptance, with no operand read and no memory write.
- R6: While `mem_req` is high and `mem_ack` is low, `mem_req`, `mem_addr`, `mem_size`, `mem_data` and `mem_fc` stay unchanged into the next cycle.
- R7: `opnd_ready` is low whenever `mem_req` is high. Each write's `mem_data` equals the operand word taken for that part. A tail write carries the unused bytes unchanged in the same word.
- R8: `undef_flag` equals the inverse of `ea_valid` at acceptance and is held until the next acceptance. The writes are still performed when the flag is set.
- R9: `cap_ca` and `cap_pc` hold the values of `cmd_ca` and `cmd_pc` at acceptance until the next acceptance.
- R10: `cmd_ready` is high only when no transfer is in progress. `done` is a one-cycle pulse in the cycle after the final acknowledge.
- R11: After reset, `cmd_ready` is 1, and `done`, `mem_req`, `opnd_ready`, `undef_flag`, `cap_ca` and `cap_pc` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command can be taken |
| cmd_len | input | 8 | Operand byte count |
| cmd_ca | input | 1 | CA control bit of the command |
| cmd_pc | input | 1 | PC control bit of the command |
| cmd_super | input | 1 | Privilege bit (1 = supervisor) |
| ea_addr | input | 32 | Latched effective address |
| ea_valid | input | 1 | Latched address was computed for this instruction |
| cap_ca | output | 1 | Captured CA bit |
| cap_pc | output | 1 | Captured PC bit |
| undef_flag | output | 1 | Result address undefined |
| opnd_valid | input | 1 | Operand word available |
| opnd_ready | output | 1 | Block requests an operand word |
| opnd_data | input | 32 | Operand word |
| mem_req | output | 1 | Write request |
| mem_ack | input | 1 | Write acknowledge |
| mem_addr | output | 32 | Write byte address |
| mem_size | output | 3 | Write size in bytes (1 to 4) |
| mem_data | output | 32 | Write data |
| mem_fc | output | 3 | Function code of the write |
| done | output | 1 | Transfer complete pulse |

## Verification
Two things can meet in one cycle: an operand word offered on `opnd_valid`, and a write that is still waiting for its acknowledge. Some table rows hold `opnd_valid` high for the whole transfer while the memory side delays `mem_ack` by up to three cycles. The bench then checks three things: that `opnd_ready` is low on every cycle with a pending write, that every write is stable until its acknowledge, and that each part's data equals the word offered for that part and not the next one. A second meeting point is the final acknowledge and the capture of a new command; the bench confirms that `cmd_ready` only returns after the `done` pulse.

// File: rtl/opw_pkg.sv
package opw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_WRITE = 2'd2,
    ST_DONE  = 2'd3
  } opw_state_t;

  localparam logic [2:0] FC_USER_DATA = 3'b001;
  localparam logic [2:0] FC_SUPV_DATA = 3'b101;
endpackage

// File: rtl/opw_seq.sv
module opw_seq
  import opw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic       len_zero,
  input  logic       opnd_valid,
  input  logic       mem_ack,
  input  logic       last_part,
  output opw_state_t state,
  output logic       accept,
  output logic       take_word,
  output logic       write_done
);
  opw_state_t nxt;

  assign accept     = (state == ST_IDLE)  && cmd_valid;
  assign take_word  = (state == ST_FETCH) && opnd_valid;
  assign write_done = (state == ST_WRITE) && mem_ack;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:  if (accept) nxt = len_zero ? ST_DONE : ST_FETCH;
      ST_FETCH: if (take_word) nxt = ST_WRITE;
      ST_WRITE: if (write_done) nxt = last_part ? ST_DONE : ST_FETCH;
      ST_DONE:  nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/opw_len_track.sv
module opw_len_track #(
  parameter int LEN_W = 8,
  parameter int BPW   = 4,
  localparam int SZ_W = $clog2(BPW + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] load_len,
  input  logic             step,
  output logic [SZ_W-1:0]  part_size,
  output logic             last_part
);
  logic [LEN_W-1:0] remain;
  logic             full_word;

  assign full_word = remain >= LEN_W'(BPW);
  assign part_size = full_word ? SZ_W'(BPW) : SZ_W'(remain);
  assign last_part = remain <= LEN_W'(BPW);

  always_ff @(posedge clk) begin
    if (!rst_n)    remain <= '0;
    else if (load) remain <= load_len;
    else if (step) remain <= remain - LEN_W'(part_size);
  end
endmodule

// File: rtl/opw_addr_gen.sv
module opw_addr_gen #(
  parameter int ADDR_W = 32,
  parameter int SZ_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] base,
  input  logic              step,
  input  logic [SZ_W-1:0]   step_size,
  output logic [ADDR_W-1:0] cur_addr
);
  always_ff @(posedge clk) begin
    if (!rst_n)    cur_addr <= '0;
    else if (load) cur_addr <= base;
    else if (step) cur_addr <= cur_addr + ADDR_W'(step_size);
  end
endmodule

// File: rtl/opnd_mem_writer.sv
module opnd_mem_writer
  import opw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 8,
  localparam int BPW   = DATA_W / 8,
  localparam int SZ_W  = $clog2(BPW + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic              cmd_ca,
  input  logic              cmd_pc,
  input  logic              cmd_super,
  input  logic [ADDR_W-1:0] ea_addr,
  input  logic              ea_valid,
  output logic              cap_ca,
  output logic              cap_pc,
  output logic              undef_flag,
  input  logic              opnd_valid,
  output logic              opnd_ready,
  input  logic [DATA_W-1:0] opnd_data,
  output logic              mem_req,
  input  logic              mem_ack,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [SZ_W-1:0]   mem_size,
  output logic [DATA_W-1:0] mem_data,
  output logic [2:0]        mem_fc,
  output logic              done
);
  opw_state_t       state;
  logic             accept, take_word, write_done, last_part;
  logic [SZ_W-1:0]  part_size;
  logic [DATA_W-1:0] word_q;
  logic [2:0]       fc_q;

  opw_seq u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid),
    .len_zero(cmd_len == '0), .opnd_valid(opnd_valid), .mem_ack(mem_ack),
    .last_part(last_part), .state(state), .accept(accept),
    .take_word(take_word), .write_done(write_done)
  );

  opw_len_track #(.LEN_W(LEN_W), .BPW(BPW)) u_len (
    .clk(clk), .rst_n(rst_n), .load(accept), .load_len(cmd_len),
    .step(write_done), .part_size(part_size), .last_part(last_part)
  );

  opw_addr_gen #(.ADDR_W(ADDR_W), .SZ_W(SZ_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .load(accept), .base(ea_addr),
    .step(write_done), .step_size(part_size), .cur_addr(mem_addr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fc_q       <= FC_USER_DATA;
      cap_ca     <= 1'b0;
      cap_pc     <= 1'b0;
      undef_flag <= 1'b0;
    end else if (accept) begin
      fc_q       <= cmd_super ? FC_SUPV_DATA : FC_USER_DATA;
      cap_ca     <= cmd_ca;
      cap_pc     <= cmd_pc;
      undef_flag <= !ea_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         word_q <= '0;
    else if (take_word) word_q <= opnd_data;
  end

  assign cmd_ready  = (state == ST_IDLE);
  assign opnd_ready = (state == ST_FETCH);
  assign mem_req    = (state == ST_WRITE);
  assign done       = (state == ST_DONE);
  assign mem_size   = part_size;
  assign mem_data   = word_q;
  assign mem_fc     = fc_q;
endmodule

// File: rtl/opw_chk.sv
module opw_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int SZ_W   = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_ready,
  input logic              opnd_ready,
  input logic              mem_req,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [SZ_W-1:0]   mem_size,
  input logic [DATA_W-1:0] mem_data,
  input logic [2:0]        mem_fc,
  input logic              done
);
  AST_FC_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_fc == 3'b001 || mem_fc == 3'b101)); // R4
  AST_SIZE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_size >= 1 && mem_size <= 4)); // R3
  AST_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_size)
                               && $stable(mem_data) && $stable(mem_fc))); // R6
  AST_NO_READ_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !opnd_ready); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (!mem_req && !opnd_ready && !done)); // R10
endmodule

bind opnd_mem_writer opw_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SZ_W(SZ_W)) u_opw_chk (
  .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .opnd_ready(opnd_ready),
  .mem_req(mem_req), .mem_ack(mem_ack), .mem_addr(mem_addr), .mem_size(mem_size),
  .mem_data(mem_data), .mem_fc(mem_fc), .done(done)
);

// File: tb/test_opnd_mem_writer.sv
`timescale 1ns/1ps
module test_opnd_mem_writer;
  typedef struct packed {
    logic [7:0]  len;
    logic [31:0] addr;
    logic        sup;
    logic        eav;
    logic        hold;
    logic [1:0]  wt;
    logic        ca;
    logic        pc;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{8'd0,   32'h1000_0000, 1'b1, 1'b1, 1'b0, 2'd0, 1'b1, 1'b0},
    '{8'd1,   32'h0000_0103, 1'b0, 1'b1, 1'b0, 2'd1, 1'b0, 1'b1},
    '{8'd2,   32'h0000_2002, 1'b1, 1'b1, 1'b0, 2'd0, 1'b1, 1'b1},
    '{8'd3,   32'h0000_3001, 1'b0, 1'b0, 1'b1, 2'd2, 1'b0, 1'b0},
    '{8'd4,   32'h0000_4000, 1'b1, 1'b1, 1'b0, 2'd0, 1'b1, 1'b0},
    '{8'd5,   32'h0000_5000, 1'b0, 1'b1, 1'b1, 2'd0, 1'b0, 1'b1},
    '{8'd7,   32'h0000_7006, 1'b1, 1'b0, 1'b0, 2'd3, 1'b1, 1'b1},
    '{8'd8,   32'hABCD_0010, 1'b0, 1'b1, 1'b1, 2'd1, 1'b0, 1'b0},
    '{8'd255, 32'hFFFF_FF00, 1'b0, 1'b1, 1'b1, 2'd1, 1'b1, 1'b0},
    '{8'd0,   32'h0000_0000, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_ca = 1'b0, cmd_pc = 1'b0, cmd_super = 1'b0, ea_valid = 1'b0;
  logic [7:0] cmd_len = '0;
  logic [31:0] ea_addr = '0, opnd_data = '0;
  logic opnd_valid = 1'b0, mem_ack = 1'b0;
  logic cmd_ready, cap_ca, cap_pc, undef_flag, opnd_ready, mem_req, done;
  logic [31:0] mem_addr, mem_data;
  logic [2:0] mem_size, mem_fc;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  opnd_mem_writer i_opnd_mem_writer (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_len(cmd_len), .cmd_ca(cmd_ca), .cmd_pc(cmd_pc), .cmd_super(cmd_super),
    .ea_addr(ea_addr), .ea_valid(ea_valid), .cap_ca(cap_ca), .cap_pc(cap_pc),
    .undef_flag(undef_flag), .opnd_valid(opnd_valid), .opnd_ready(opnd_ready),
    .opnd_data(opnd_data), .mem_req(mem_req), .mem_ack(mem_ack),
    .mem_addr(mem_addr), .mem_size(mem_size), .mem_data(mem_data),
    .mem_fc(mem_fc), .done(done)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_xfer(input int vi);
    vec_t v = VEC[vi];
    int nfull = int'(v.len) / 4;
    int tail  = int'(v.len) % 4;
    int nparts = nfull + (tail != 0 ? 1 : 0);
    logic [2:0] fc_exp = v.sup ? 3'b101 : 3'b001;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_len = v.len; ea_addr = v.addr; cmd_super = v.sup;
    ea_valid = v.eav; cmd_ca = v.ca; cmd_pc = v.pc;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0; cmd_super = ~v.sup; cmd_ca = ~v.ca; cmd_pc = ~v.pc;
    ea_addr = ~v.addr; ea_valid = ~v.eav; cmd_len = 8'hFF;
    if (v.len == 8'd0) begin
      check(done && !mem_req && !opnd_ready, "R5 zero-length done",
            {61'd0, done, mem_req, opnd_ready}, 64'b100);
    end
    for (int p = 0; p < nparts; p++) begin
      logic [31:0] word = 32'hC0DE_0000 + (vi << 8) + p;
      logic [2:0]  sz_exp = (p < nfull) ? 3'd4 : 3'(tail);
      logic [31:0] a_exp = v.addr + 32'(4 * p);
      int guard = 0;
      while (!opnd_ready && guard < 10) begin
        check(!mem_req, "R7 no write before read", 64'(mem_req), 64'd0);
        @(negedge clk);
        guard++;
      end
      check(opnd_ready, "R7 read requested", 64'(opnd_ready), 64'd1);
      opnd_valid = 1'b1; opnd_data = word;
      @(posedge clk);
      @(negedge clk);
      if (!v.hold) opnd_valid = 1'b0;
      check(mem_req, "R1 write issued per part", 64'(mem_req), 64'd1);
      check(mem_addr == a_exp, "R2 ascending address", 64'(mem_addr), 64'(a_exp));
      check(mem_size == sz_exp, "R3 R1 write size", 64'(mem_size), 64'(sz_exp));
      check(mem_fc == fc_exp, "R4 function code", 64'(mem_fc), 64'(fc_exp));
      check(mem_data == word, "R7 data matches word", 64'(mem_data), 64'(word));
      for (int w = 0; w < int'(v.wt); w++) begin
        @(negedge clk);
        check(mem_req && mem_addr == a_exp && mem_size == sz_exp && mem_data == word,
              "R6 held until ack", 64'(mem_addr), 64'(a_exp));
        check(!opnd_ready, "R7 no read while pending", 64'(opnd_ready), 64'd0);
      end
      if (v.hold) opnd_data = word + 32'd1;
      mem_ack = 1'b1;
      @(posedge clk);
      @(negedge clk);
      mem_ack = 1'b0;
      if (p == nparts - 1) begin
        opnd_valid = 1'b0;
        check(done && !opnd_ready && !mem_req, "R1 R10 done after final ack",
              {61'd0, done, opnd_ready, mem_req}, 64'b100);
      end else begin
        check(!done, "R10 no early done", 64'(done), 64'd0);
      end
    end
    check(undef_flag == !v.eav, "R8 undefined flag", 64'(undef_flag), 64'(!v.eav));
    check(cap_ca == v.ca && cap_pc == v.pc, "R9 captured control bits",
          {62'd0, cap_ca, cap_pc}, {62'd0, v.ca, v.pc});
    @(negedge clk);
    check(!done && cmd_ready && !mem_req && !opnd_ready, "R10 done one cycle, idle again",
          {60'd0, done, cmd_ready, mem_req, opnd_ready}, 64'b0100);
    check(undef_flag == !v.eav, "R8 flag held after done", 64'(undef_flag), 64'(!v.eav));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(cmd_ready && !done && !mem_req && !opnd_ready && !undef_flag && !cap_ca && !cap_pc,
          "R11 reset state",
          {57'd0, cmd_ready, done, mem_req, opnd_ready, undef_flag, cap_ca, cap_pc},
          64'b1000000);
    rst_n = 1'b1;
    @(negedge clk);
    check(cmd_ready && !done, "R11 idle after reset", {62'd0, cmd_ready, done}, 64'b10);
    for (int i = 0; i < NV; i++) run_xfer(i);
    opnd_valid = 1'b1;
    repeat (4) @(negedge clk);
    check(!mem_req && cmd_ready, "R7 idle ignores operand offers",
          {62'd0, mem_req, cmd_ready}, 64'b01);
    opnd_valid = 1'b0;
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule